// File: doc/BRIEF.md
# USB Suspend/Resume Event Controller

This block collects bus power-management events for a USB hub and raises one interrupt line to the microcontroller. A global-suspend pulse, a resume pulse tagged with the port it arrived on, and a remote-wakeup pulse from an external source each set a sticky bit in a four-bit event register. A programmable enable register and a write-only visibility mask gate each bit onto `irq_o`.

The block also times SE0 on the upstream line. When SE0 lasts longer than a parameterized reset window (3 ms by default), the block treats it as a bus reset. Bit 3 of both the enable and the mask registers selects what that reset does. With both bits set, the reset is kept away from the processor: the block asserts a USB-only reset output, records the event in bit 3, and can interrupt the processor. Otherwise it asserts the system reset output.

Software reads the three pulse-driven event bits with clear-on-read. It clears the bus-reset bit explicitly by writing 0 to it.

Top module: `usb_susp_evt_ctrl`

## Requirements
- R1: After reset the event, enable and mask registers read 0x00, and `irq_o`, `usb_rst_o` and `sys_rst_o` are low.
- R2: A `susp_det_i` pulse sets event bit 0 and a `wake_i` pulse sets event bit 2.
- R3: A `rsm_det_i` pulse sets event bit 1 unless `rsm_port_i` equals 1. A resume on port 1 leaves the event register unchanged.
- R4: Reading the event register (select 0) returns bits 3..0, with bits 7..4 as zero. The read clears bits 2..0 at the following clock edge.
- R5: Writing the event register clears bit 3 when `reg_wdata_i[3]` is 0. Writing 1 never sets a bit, and bits 2..0 ignore writes.
- R6: The enable register (select 1) stores `reg_wdata_i[3:0]` and reads back with bits 7..4 as zero. The mask register (select 2) is write-only and always reads 0x00.
- R7: `irq_o` is high while any event bit has both its enable bit and its mask bit set.
- R8: SE0 sampled for RESET_CYC = CLK_KHZ*RESET_MS cycles or fewer is not a bus reset. The SE0 timer restarts whenever the line leaves SE0.
- R9: With enable bit 3 and mask bit 3 both set, SE0 sampled for RESET_CYC+1 cycles sets event bit 3 and raises `usb_rst_o` at that edge. `usb_rst_o` stays high until the first edge that samples the line out of SE0, and `sys_rst_o` stays low.
- R10: With reset separation off, the same SE0 raises `sys_rst_o` instead. `usb_rst_o` stays low and event bit 3 is not set.
- R11: An event that arrives in the same cycle as an event-register read stays set after the read-clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| susp_det_i | input | 1 | Global suspend detected, one-cycle pulse |
| rsm_det_i | input | 1 | Resume signaling detected, one-cycle pulse |
| rsm_port_i | input | PORT_W | Port index for the resume pulse |
| wake_i | input | 1 | External remote-wakeup request, one-cycle pulse |
| line_se0_i | input | 1 | Upstream line is in SE0 |
| reg_sel_i | input | 2 | Register select: 0 event, 1 enable, 2 mask |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected register |
| irq_o | output | 1 | Suspend/resume interrupt |
| usb_rst_o | output | 1 | USB-only reset while a separated bus reset lasts |
| sys_rst_o | output | 1 | System reset while a non-separated bus reset lasts |

## Verification
A wrong bit in the event register shows on `irq_o` in the same cycle once that bit is enabled and visible. It also shows on `reg_rdata_o` at the next read, and a stale clear-on-read stays wrong on a second read. An SE0 counter that is off by one, or that fails to restart, moves the rise of `usb_rst_o` or `sys_rst_o` away from edge RESET_CYC+1. An error in the separation decision shows as the wrong reset output, or as bit 3 differing, within one cycle of detection.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  typedef enum logic [1:0] {
    SEL_EVT  = 2'd0,
    SEL_EN   = 2'd1,
    SEL_MSK  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int EVT_W  = 4;
  localparam int B_SUSP = 0;
  localparam int B_RSM  = 1;
  localparam int B_WAKE = 2;
  localparam int B_BUS  = 3;
endpackage

// File: rtl/ssr_se0_timer.sv
module ssr_se0_timer #(
  parameter int LIMIT = 36000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic se0_i,
  output logic det_o,
  output logic hold_o
);
  localparam int CNT_W = $clog2(LIMIT + 2);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(LIMIT);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(LIMIT + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!se0_i)         cnt_q <= '0;
    else if (cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
  end

  // this edge is the (LIMIT+1)-th consecutive SE0 sample
  assign det_o  = se0_i && (cnt_q == CNT_LIM);
  assign hold_o = se0_i && (cnt_q >= CNT_LIM);
endmodule

// File: rtl/ssr_evt_reg.sv
module ssr_evt_reg
  import ssr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_W-1:0] set_i,
  input  logic             rd_clr_i,
  input  logic             wr_i,
  input  logic [EVT_W-1:0] wdata_i,
  output logic [EVT_W-1:0] q_o
);
  for (genvar i = 0; i < EVT_W; i++) begin : g_bit
    if (i == B_BUS) begin : g_sw_clr
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       q_o[i] <= 1'b0;
        else if (set_i[i]) q_o[i] <= 1'b1;
        else if (wr_i)     q_o[i] <= q_o[i] & wdata_i[i];
      end
    end else begin : g_rd_clr
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       q_o[i] <= 1'b0;
        else if (set_i[i]) q_o[i] <= 1'b1;
        else if (rd_clr_i) q_o[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ssr_cfg_reg.sv
module ssr_cfg_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (wr_i) q_o <= d_i;
  end
endmodule

// File: rtl/usb_susp_evt_ctrl.sv
module usb_susp_evt_ctrl
  import ssr_pkg::*;
#(
  parameter int CLK_KHZ   = 12000,
  parameter int RESET_MS  = 3,
  parameter int NUM_PORTS = 4,
  parameter int EXCL_PORT = 1,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              susp_det_i,
  input  logic              rsm_det_i,
  input  logic [PORT_W-1:0] rsm_port_i,
  input  logic              wake_i,
  input  logic              line_se0_i,
  input  logic [1:0]        reg_sel_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              irq_o,
  output logic              usb_rst_o,
  output logic              sys_rst_o
);
  localparam int SE0_LIMIT = CLK_KHZ * RESET_MS;

  reg_sel_e         sel;
  logic [EVT_W-1:0] evt_q, en_q, msk_q, evt_set;
  logic             sep, se0_det, se0_hold;
  logic             usb_rst_q, sys_rst_q;
  logic             unused_wdata;

  assign sel          = reg_sel_e'(reg_sel_i);
  assign unused_wdata = ^reg_wdata_i[7:EVT_W];
  assign sep          = en_q[B_BUS] & msk_q[B_BUS];

  ssr_se0_timer #(.LIMIT(SE0_LIMIT)) u_se0 (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .se0_i (line_se0_i),
    .det_o (se0_det),
    .hold_o(se0_hold)
  );

  always_comb begin
    evt_set         = '0;
    evt_set[B_SUSP] = susp_det_i;
    evt_set[B_RSM]  = rsm_det_i && (rsm_port_i != PORT_W'(EXCL_PORT));
    evt_set[B_WAKE] = wake_i;
    evt_set[B_BUS]  = se0_det && sep;
  end

  ssr_evt_reg u_evt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (evt_set),
    .rd_clr_i(reg_rd_i && (sel == SEL_EVT)),
    .wr_i    (reg_wr_i && (sel == SEL_EVT)),
    .wdata_i (reg_wdata_i[EVT_W-1:0]),
    .q_o     (evt_q)
  );

  ssr_cfg_reg #(.WIDTH(EVT_W)) u_en (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (reg_wr_i && (sel == SEL_EN)),
    .d_i   (reg_wdata_i[EVT_W-1:0]),
    .q_o   (en_q)
  );

  ssr_cfg_reg #(.WIDTH(EVT_W)) u_msk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (reg_wr_i && (sel == SEL_MSK)),
    .d_i   (reg_wdata_i[EVT_W-1:0]),
    .q_o   (msk_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      usb_rst_q <= 1'b0;
      sys_rst_q <= 1'b0;
    end else begin
      usb_rst_q <= se0_hold && sep;
      sys_rst_q <= se0_hold && !sep;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (sel)
      SEL_EVT: reg_rdata_o[EVT_W-1:0] = evt_q;
      SEL_EN:  reg_rdata_o[EVT_W-1:0] = en_q;
      default: reg_rdata_o = '0; // mask is write-only
    endcase
  end

  assign irq_o     = |(evt_q & en_q & msk_q);
  assign usb_rst_o = usb_rst_q;
  assign sys_rst_o = sys_rst_q;
endmodule

// File: rtl/ssr_checker.sv
module ssr_checker #(
  parameter int LIMIT = 36000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       line_se0_i,
  input logic       susp_det_i,
  input logic       rsm_det_i,
  input logic       wake_i,
  input logic       reg_rd_i,
  input logic [1:0] reg_sel_i,
  input logic [7:0] reg_rdata_o,
  input logic [3:0] evt_q,
  input logic       usb_rst_o,
  input logic       sys_rst_o
);
  logic [31:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         run_q <= '0;
    else if (!line_se0_i) run_q <= '0;
    else if (run_q != 32'hFFFF_FFFF) run_q <= run_q + 1'b1;
  end

  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[7:4] == 4'h0); // R4

  AST_RST_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(usb_rst_o && sys_rst_o)); // R10

  AST_RST_AFTER_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (usb_rst_o || sys_rst_o) |-> (run_q > LIMIT)); // R8

  AST_SEP_RECORDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(usb_rst_o) |-> evt_q[3]); // R9

  AST_RD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_sel_i == 2'd0 && !susp_det_i && !rsm_det_i && !wake_i)
      |=> (evt_q[2:0] == 3'b000)); // R4

  AST_SUSP_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_det_i |=> evt_q[0]); // R11
endmodule

bind usb_susp_evt_ctrl ssr_checker #(.LIMIT(CLK_KHZ * RESET_MS)) u_ssr_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .line_se0_i (line_se0_i),
  .susp_det_i (susp_det_i),
  .rsm_det_i  (rsm_det_i),
  .wake_i     (wake_i),
  .reg_rd_i   (reg_rd_i),
  .reg_sel_i  (reg_sel_i),
  .reg_rdata_o(reg_rdata_o),
  .evt_q      (evt_q),
  .usb_rst_o  (usb_rst_o),
  .sys_rst_o  (sys_rst_o)
);

// File: tb/usb_susp_evt_ctrl_test.sv
`timescale 1ns/1ps
module usb_susp_evt_ctrl_test;
  localparam int CLK_KHZ = 10;
  localparam int RESET_MS = 3;
  localparam int LIMIT = CLK_KHZ * RESET_MS;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       susp_det_i = 0, rsm_det_i = 0, wake_i = 0, line_se0_i = 0;
  logic [1:0] rsm_port_i = 0;
  logic [1:0] reg_sel_i = 2'd3;
  logic       reg_wr_i = 0, reg_rd_i = 0;
  logic [7:0] reg_wdata_i = 0;
  logic [7:0] reg_rdata_o;
  logic       irq_o, usb_rst_o, sys_rst_o;

  int vectors = 0;
  int fails = 0;
  logic [7:0] rv;

  always #5 clk_i = ~clk_i;

  usb_susp_evt_ctrl #(.CLK_KHZ(CLK_KHZ), .RESET_MS(RESET_MS), .NUM_PORTS(4), .EXCL_PORT(1)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .susp_det_i(susp_det_i), .rsm_det_i(rsm_det_i),
    .rsm_port_i(rsm_port_i), .wake_i(wake_i), .line_se0_i(line_se0_i),
    .reg_sel_i(reg_sel_i), .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o),
    .usb_rst_o(usb_rst_o), .sys_rst_o(sys_rst_o)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk_i);
    reg_sel_i = sel; reg_wdata_i = d; reg_wr_i = 1;
    @(negedge clk_i);
    reg_wr_i = 0; reg_sel_i = 2'd3;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk_i);
    reg_sel_i = sel; reg_rd_i = 1;
    #1 d = reg_rdata_o;
    @(negedge clk_i);
    reg_rd_i = 0; reg_sel_i = 2'd3;
  endtask

  task automatic pulse(input int which, input logic [1:0] port);
    @(negedge clk_i);
    case (which)
      0: susp_det_i = 1;
      1: begin rsm_det_i = 1; rsm_port_i = port; end
      default: wake_i = 1;
    endcase
    @(negedge clk_i);
    susp_det_i = 0; rsm_det_i = 0; wake_i = 0;
  endtask

  // hold SE0 for n sampled edges, then sample outputs before releasing
  task automatic se0_hold(input int n);
    @(negedge clk_i);
    line_se0_i = 1;
    repeat (n) @(negedge clk_i);
  endtask

  task automatic se0_release();
    line_se0_i = 0;
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    rd(2'd0, rv); chk("R1 evt", rv, 8'h00);
    rd(2'd1, rv); chk("R1 en", rv, 8'h00);
    rd(2'd2, rv); chk("R1 msk", rv, 8'h00);
    chk("R1 outs", {5'b0, irq_o, usb_rst_o, sys_rst_o}, 8'h00);
  endtask

  task automatic t_susp_wake();
    pulse(0, 0); rd(2'd0, rv); chk("R2 susp", rv, 8'h01);
    pulse(2, 0); rd(2'd0, rv); chk("R2 wake", rv, 8'h04);
  endtask

  task automatic t_resume();
    pulse(1, 2'd1); rd(2'd0, rv); chk("R3 port1 ignored", rv, 8'h00);
    pulse(1, 2'd0); rd(2'd0, rv); chk("R3 port0", rv, 8'h02);
    pulse(1, 2'd3); rd(2'd0, rv); chk("R3 port3", rv, 8'h02);
  endtask

  task automatic t_readclr();
    pulse(0, 0); pulse(2, 0); pulse(1, 2'd2);
    rd(2'd0, rv); chk("R4 all", rv, 8'h07);
    rd(2'd0, rv); chk("R4 cleared", rv, 8'h00);
  endtask

  task automatic t_cfg();
    wr(2'd1, 8'hFF); rd(2'd1, rv); chk("R6 en", rv, 8'h0F);
    wr(2'd2, 8'hFF); rd(2'd2, rv); chk("R6 msk wo", rv, 8'h00);
    wr(2'd1, 8'h00); wr(2'd2, 8'h00);
  endtask

  task automatic t_irq();
    wr(2'd1, 8'h01); pulse(0, 0);
    chk("R7 masked", {7'b0, irq_o}, 8'h00);
    wr(2'd2, 8'h01);
    chk("R7 visible", {7'b0, irq_o}, 8'h01);
    rd(2'd0, rv);
    chk("R7 after clear", {7'b0, irq_o}, 8'h00);
    wr(2'd1, 8'h02); wr(2'd2, 8'h04); pulse(2, 0);
    chk("R7 split en/msk", {7'b0, irq_o}, 8'h00);
    rd(2'd0, rv);
    wr(2'd1, 8'h00); wr(2'd2, 8'h00);
  endtask

  task automatic t_se0_short();
    wr(2'd1, 8'h08); wr(2'd2, 8'h08);
    se0_hold(LIMIT);
    chk("R8 at window", {6'b0, usb_rst_o, sys_rst_o}, 8'h00);
    se0_release();
    se0_hold(LIMIT);
    chk("R8 restart", {6'b0, usb_rst_o, sys_rst_o}, 8'h00);
    se0_release();
    rd(2'd0, rv); chk("R8 no event", rv, 8'h00);
  endtask

  task automatic t_sep_on();
    se0_hold(LIMIT + 1);
    chk("R9 rst outs", {6'b0, usb_rst_o, sys_rst_o}, 8'h02);
    chk("R9 irq", {7'b0, irq_o}, 8'h01);
    @(negedge clk_i);
    chk("R9 held", {6'b0, usb_rst_o, sys_rst_o}, 8'h02);
    se0_release();
    chk("R9 released", {6'b0, usb_rst_o, sys_rst_o}, 8'h00);
    rd(2'd0, rv); chk("R9 evt", rv, 8'h08);
    rd(2'd0, rv); chk("R5 not read-clear", rv, 8'h08);
    wr(2'd0, 8'hFF); rd(2'd0, rv); chk("R5 write 1", rv, 8'h08);
    wr(2'd0, 8'h00); rd(2'd0, rv); chk("R5 write 0", rv, 8'h00);
  endtask

  task automatic t_sep_off();
    wr(2'd2, 8'h00);
    se0_hold(LIMIT + 1);
    chk("R10 rst outs", {6'b0, usb_rst_o, sys_rst_o}, 8'h01);
    se0_release();
    chk("R10 released", {6'b0, usb_rst_o, sys_rst_o}, 8'h00);
    rd(2'd0, rv); chk("R10 evt", rv, 8'h00);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_set_vs_clr();
    @(negedge clk_i);
    reg_sel_i = 2'd0; reg_rd_i = 1; susp_det_i = 1;
    #1 rv = reg_rdata_o;
    chk("R11 read data", rv, 8'h00);
    @(negedge clk_i);
    reg_rd_i = 0; susp_det_i = 0; reg_sel_i = 2'd3;
    rd(2'd0, rv); chk("R11 kept", rv, 8'h01);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    t_reset();
    t_susp_wake();
    t_resume();
    t_readclr();
    t_cfg();
    t_irq();
    t_se0_short();
    t_sep_on();
    t_sep_off();
    t_set_vs_clr();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule